// File: doc/BRIEF.md
# Shadowed Real-Time Seconds Counter

This block keeps wall time as a 32-bit seconds count and a sub-second count. Both counts advance on rising edges of a free-running slow reference clock, nominally 32.768 kHz. The counts are not read directly from the bus. After every fixed group of slow ticks, a small state machine copies both counts into a pair of bus-side registers. While that copy is pending, it raises a busy flag. Between copies the bus-side values stay still, so software can read them, or load a new seconds value, without racing the counter.

Reading the sub-second register also captures the bus-side seconds value into a shadow register. A later read of the shadow register therefore gives seconds that belong with the sub-second value already read, even if a copy or a write happens in between.

The slow clock is never used as a clock inside the block. It is brought into the bus clock domain through a two-flop synchronizer, and its rising edge becomes a one-cycle tick enable. The sub-second count uses a fractional accumulator: on every tick it adds SUBSEC_PER_S and subtracts TICK_HZ when the sum reaches it. After n ticks with no load in between, the total number of sub-second steps is floor(n·SUBSEC_PER_S / TICK_HZ).

Top module: `rtc_shadow_seconds`

Snapshot state machine:

| State | Meaning | busy |
|---|---|---|
| SNAP_IDLE | Registers stable, writes accepted | 0 |
| SNAP_COPY | Live counts copied into the bus registers | 1 |
| SNAP_HOLD | Waits for the next tick | 1 |

Transitions:
- SNAP_IDLE to SNAP_COPY: the snapshot-due pulse.
- SNAP_COPY to SNAP_HOLD: always, after one cycle.
- SNAP_HOLD to SNAP_IDLE: on the next tick.

## Requirements
- R1: After reset, reads of seconds (offset 0x08), sub-seconds (0x10), shadow (0x0C) and busy (0x04) all return 0.
- R2: With no load, after n ticks the live counts hold total steps T = floor(n·SUBSEC_PER_S/TICK_HZ): sub-seconds = T mod SUBSEC_PER_S and seconds = start + T/SUBSEC_PER_S. The sub-second count wraps from SUBSEC_PER_S−1 to 0 and increments seconds. Seconds wrap modulo 2^32.
- R3: The seconds and sub-second bus registers are loaded with the live counts after every SNAP_TICKS-th tick since reset. Outside a snapshot and an accepted seconds write, they do not change.
- R4: Busy reads as bit 0 of offset 0x04, with all other bits 0. It rises after each snapshot tick and falls on the next tick, so each busy window lasts exactly one tick period.
- R5: A read of offset 0x10 copies the bus-side seconds value into the shadow register at 0x0C. The copy holds until the next such read.
- R6: A write to offset 0x08 while busy is 1 has no effect on the live or bus-side seconds.
- R7: A write to offset 0x08 while busy is 0 loads the written value into the live and bus-side seconds. It also clears the live and bus-side sub-second counts and the fractional accumulator.
- R8: Read data appears on bus_rdata in the cycle after the strobe. Unmapped offsets read 0. Writes to any offset other than 0x08 have no effect.
- R9: The live sub-second count never reaches SUBSEC_PER_S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Asynchronous slow reference clock, sampled as data |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |

## Verification
The properties assume that slow-clock rising edges are separated by many bus cycles. Under that assumption, at most one tick falls inside a busy window and no tick falls inside the one-cycle copy state. The bench runs the slow clock at 48 bus cycles per period and uses a small configuration of 64 ticks per second and 10 sub-second steps. It issues every write and read sequence well inside one slow period after busy falls, or inside a busy window, so that each access lands in a known state. With that, the bench can predict every snapshot from its own count of slow edges.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    // Register byte offsets (software contract)
    localparam int OFS_BUSY   = 'h04;
    localparam int OFS_SEC    = 'h08;
    localparam int OFS_SHADOW = 'h0C;
    localparam int OFS_SUBSEC = 'h10;

    typedef enum logic [1:0] {
        SNAP_IDLE = 2'd0,
        SNAP_COPY = 2'd1,
        SNAP_HOLD = 2'd2
    } snap_state_e;

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic tick
);

    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], async_in};
        end
    end

    assign tick = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
    parameter int TICK_HZ      = 32768,
    parameter int SUBSEC_PER_S = 1000,
    parameter int SNAP_TICKS   = 8,
    parameter int SEC_W        = 32
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  tick,
    input  logic                                  load,
    input  logic [SEC_W-1:0]                      load_val,
    output logic [SEC_W-1:0]                      live_sec,
    output logic [$clog2(SUBSEC_PER_S)-1:0]       live_sub,
    output logic                                  snap_due
);

    localparam int SUB_W = $clog2(SUBSEC_PER_S);
    localparam int ACC_W = $clog2(TICK_HZ + SUBSEC_PER_S);
    localparam int PH_W  = $clog2(SNAP_TICKS);

    localparam logic [ACC_W-1:0] STEP     = ACC_W'(SUBSEC_PER_S);
    localparam logic [ACC_W-1:0] WRAP     = ACC_W'(TICK_HZ);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBSEC_PER_S - 1);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SNAP_TICKS - 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             carry;
    logic [PH_W-1:0]  phase;

    always_comb begin
        acc_sum = acc + STEP;
        carry   = (acc_sum >= WRAP);
    end

    // Snapshot phase: independent of seconds loads, so the copy cadence never slips
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            snap_due <= 1'b0;
        end else begin
            snap_due <= 1'b0;
            if (tick) begin
                snap_due <= (phase == PH_LAST);
                phase    <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            end
        end
    end

    // Fractional accumulator and time counters; a load wins over a tick
    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            live_sub <= '0;
            live_sec <= '0;
        end else if (load) begin
            acc      <= '0;
            live_sub <= '0;
            live_sec <= load_val;
        end else if (tick) begin
            if (carry) begin
                acc <= acc_sum - WRAP;
                if (live_sub == SUB_LAST) begin
                    live_sub <= '0;
                    live_sec <= live_sec + 1'b1;
                end else begin
                    live_sub <= live_sub + 1'b1;
                end
            end else begin
                acc <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/rtc_snap_fsm.sv
module rtc_snap_fsm
    import rtc_shadow_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int SUB_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             snap_due,
    input  logic [SEC_W-1:0] live_sec,
    input  logic [SUB_W-1:0] live_sub,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic             busy,
    output logic [SEC_W-1:0] bus_sec,
    output logic [SUB_W-1:0] bus_sub
);

    snap_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SNAP_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SNAP_IDLE: if (snap_due) state_nxt = SNAP_COPY;
            SNAP_COPY: state_nxt = SNAP_HOLD;
            SNAP_HOLD: if (tick) state_nxt = SNAP_IDLE;
            default:   state_nxt = SNAP_IDLE;
        endcase
    end

    assign busy = (state != SNAP_IDLE);

    // Outputs: bus-side registers
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_sec <= '0;
            bus_sub <= '0;
        end else if (state == SNAP_COPY) begin
            bus_sec <= live_sec;
            bus_sub <= live_sub;
        end else if (load) begin
            bus_sec <= load_val;
            bus_sub <= '0;
        end
    end

endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
    import rtc_shadow_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SUB_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] bus_sec,
    input  logic [SUB_W-1:0]  bus_sub,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] shadow,
    output logic              load,
    output logic [DATA_W-1:0] load_val
);

    localparam logic [ADDR_W-1:0] A_BUSY   = ADDR_W'(OFS_BUSY);
    localparam logic [ADDR_W-1:0] A_SEC    = ADDR_W'(OFS_SEC);
    localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(OFS_SHADOW);
    localparam logic [ADDR_W-1:0] A_SUBSEC = ADDR_W'(OFS_SUBSEC);

    logic rd_stb;
    logic [DATA_W-1:0] rd_mux;

    assign rd_stb   = bus_sel & ~bus_wr;
    assign load     = bus_sel & bus_wr & (bus_addr == A_SEC) & ~busy;
    assign load_val = bus_wdata;

    always_comb begin
        unique case (bus_addr)
            A_BUSY:   rd_mux = DATA_W'(busy);
            A_SEC:    rd_mux = bus_sec;
            A_SHADOW: rd_mux = shadow;
            A_SUBSEC: rd_mux = DATA_W'(bus_sub);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            shadow    <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_mux;
            if (bus_addr == A_SUBSEC) shadow <= bus_sec;
        end
    end

endmodule

// File: rtl/rtc_shadow_seconds.sv
module rtc_shadow_seconds #(
    parameter int TICK_HZ      = 32768,
    parameter int SUBSEC_PER_S = 1000,
    parameter int SNAP_TICKS   = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int SUB_W = $clog2(SUBSEC_PER_S);

    logic              tick;
    logic              snap_due;
    logic              busy;
    logic              load;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] live_sec;
    logic [SUB_W-1:0]  live_sub;
    logic [DATA_W-1:0] bus_sec;
    logic [SUB_W-1:0]  bus_sub;
    logic [DATA_W-1:0] shadow;

    rtc_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (slow_clk),
        .tick     (tick)
    );

    rtc_time_core #(
        .TICK_HZ      (TICK_HZ),
        .SUBSEC_PER_S (SUBSEC_PER_S),
        .SNAP_TICKS   (SNAP_TICKS),
        .SEC_W        (DATA_W)
    ) i_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .live_sec (live_sec),
        .live_sub (live_sub),
        .snap_due (snap_due)
    );

    rtc_snap_fsm #(.SEC_W(DATA_W), .SUB_W(SUB_W)) i_snap (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .snap_due (snap_due),
        .live_sec (live_sec),
        .live_sub (live_sub),
        .load     (load),
        .load_val (load_val),
        .busy     (busy),
        .bus_sec  (bus_sec),
        .bus_sub  (bus_sub)
    );

    rtc_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W)) i_port (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .bus_sec   (bus_sec),
        .bus_sub   (bus_sub),
        .bus_rdata (bus_rdata),
        .shadow    (shadow),
        .load      (load),
        .load_val  (load_val)
    );

endmodule

// File: rtl/rtc_shadow_seconds_chk.sv
module rtc_shadow_seconds_chk
    import rtc_shadow_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int SUB_W        = 10,
    parameter int SUBSEC_PER_S = 1000
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              busy,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] live_sec,
    input logic [SUB_W-1:0]  live_sub,
    input logic [DATA_W-1:0] bus_sec,
    input logic [SUB_W-1:0]  bus_sub,
    input logic [DATA_W-1:0] shadow,
    input logic              load
);

    logic wr_sec;
    logic rd_sub;
    assign wr_sec = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_SEC));
    assign rd_sub = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFS_SUBSEC));

    a_r9_sub_in_range: assert property (@(posedge clk) disable iff (rst)
        live_sub < SUB_W'(SUBSEC_PER_S));

    a_r4_busy_falls_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_sec) |=> (live_sec == $past(live_sec) || live_sec == $past(live_sec) + 1'b1));

    a_r7_idle_write_loads: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_sec) |=> (live_sec == $past(bus_wdata) && live_sub == '0 && bus_sec == $past(bus_wdata)));

    a_r5_shadow_capture: assert property (@(posedge clk) disable iff (rst)
        rd_sub |=> shadow == $past(bus_sec));

    a_r3_bus_regs_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> ($stable(bus_sec) && $stable(bus_sub)));

endmodule

bind rtc_shadow_seconds rtc_shadow_seconds_chk #(
    .DATA_W       (DATA_W),
    .ADDR_W       (ADDR_W),
    .SUB_W        (SUB_W),
    .SUBSEC_PER_S (SUBSEC_PER_S)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .busy      (busy),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .live_sec  (live_sec),
    .live_sub  (live_sub),
    .bus_sec   (bus_sec),
    .bus_sub   (bus_sub),
    .shadow    (shadow),
    .load      (load)
);

// File: tb/test_rtc_shadow_seconds.sv
module test_rtc_shadow_seconds;

    localparam int H    = 64;
    localparam int S    = 10;
    localparam int SNAP = 8;

    logic        clk;
    logic        rst;
    logic        slow_clk;
    logic        bus_sel;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    int          checks;
    int          errors;
    longint      edges;
    longint      ref_edge;
    logic [31:0] base_sec;

    rtc_shadow_seconds #(
        .TICK_HZ(H), .SUBSEC_PER_S(S), .SNAP_TICKS(SNAP),
        .SYNC_STAGES(2), .DATA_W(32), .ADDR_W(8)
    ) i_rtc_shadow_seconds (
        .clk(clk), .rst(rst), .slow_clk(slow_clk),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // 250 MHz bus clock, posedges at multiples of 4 ns
    initial begin
        clk = 1'b1;
        forever #2 clk = ~clk;
    end

    // Slow clock: 48 bus cycles per period, edges offset from bus edges
    initial begin
        slow_clk = 1'b0;
        #2;
        forever #96 slow_clk = ~slow_clk;
    end

    always @(posedge slow_clk) if (!rst) edges <= edges + 1;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #700000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Expected bus-side pair for a snapshot taken at slow-edge count n
    task automatic model(input longint n, output logic [31:0] es, output logic [31:0] ems);
        longint total;
        total = ((n - ref_edge) * S) / H;
        es    = base_sec + 32'(total / S);
        ems   = 32'(total % S);
    endtask

    task automatic wait_busy(input logic [31:0] level);
        logic [31:0] d;
        for (int g = 0; g < 400; g++) begin
            bus_read(8'h04, d);
            if (d == level) return;
        end
        check("R4 busy level reached", d, level);
    endtask

    // Wait for a fall of busy and check the snapshot just published
    task automatic window_check();
        logic [31:0] s, ms, es, ems, b;
        wait_busy(32'd1);
        wait_busy(32'd0);
        check("R4 busy window ends one tick after snapshot", 32'(edges % SNAP), 32'd1);
        model(edges - 1, es, ems);
        bus_read(8'h08, s);
        bus_read(8'h10, ms);
        bus_read(8'h04, b);
        check("R2/R3 snapshot seconds", s, es);
        check("R2/R3 snapshot subseconds", ms, ems);
        check("R4 busy word idle", b, 32'd0);
    endtask

    initial begin
        logic [31:0] d, es, ems, old_sec;
        checks = 0; errors = 0; edges = 0; ref_edge = 0; base_sec = '0;
        rst = 1'b1; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        #200;
        rst = 1'b0;

        // R1 reset state
        bus_read(8'h08, d); check("R1 seconds after reset", d, 32'd0);
        bus_read(8'h10, d); check("R1 subseconds after reset", d, 32'd0);
        bus_read(8'h0C, d); check("R1 shadow after reset", d, 32'd0);
        bus_read(8'h04, d); check("R1 busy after reset", d, 32'd0);

        // R2, R3, R4, R9: sweep snapshots across several second rollovers
        for (int w = 0; w < 40; w++) window_check();

        // R5 and R7: capture shadow, then load a new seconds value in the idle window
        wait_busy(32'd1);
        wait_busy(32'd0);
        model(edges - 1, es, ems);
        old_sec = es;
        bus_read(8'h10, d);
        check("R5 subsecond read before capture", d, ems);
        ref_edge = edges;
        base_sec = 32'hFFFF_FFFF;
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h0C, d); check("R5 shadow keeps seconds from subsecond read", d, old_sec);
        bus_read(8'h08, d); check("R7 seconds loaded while idle", d, 32'hFFFF_FFFF);
        bus_read(8'h10, d); check("R7 subseconds cleared by load", d, 32'd0);
        bus_read(8'h10, d);
        bus_read(8'h0C, d); check("R5 shadow recaptured after new read", d, 32'hFFFF_FFFF);

        // R2 seconds wrap past 2^32-1, R7 fraction restarted at the load
        for (int w = 0; w < 12; w++) window_check();

        // R6: write during busy is ignored
        for (int k = 0; k < 4; k++) begin
            wait_busy(32'd1);
            bus_write(8'h08, 32'hA5A5_0000 + 32'(k));
            wait_busy(32'd0);
            model(edges - 1, es, ems);
            bus_read(8'h08, d);
            check("R6 busy write left seconds unchanged", d, es);
        end

        // R8: unmapped reads, writes to other offsets
        wait_busy(32'd1);
        wait_busy(32'd0);
        model(edges - 1, es, ems);
        bus_write(8'h10, 32'd7);
        bus_write(8'h0C, 32'h1234);
        bus_write(8'h04, 32'd1);
        bus_read(8'h10, d); check("R8 write to subseconds ignored", d, ems);
        bus_read(8'h0C, d); check("R8 write to shadow ignored", d, es);
        bus_read(8'h04, d); check("R8 write to busy ignored", d, 32'd0);
        bus_read(8'h14, d); check("R8 unmapped offset reads zero", d, 32'd0);
        bus_read(8'h00, d); check("R8 offset zero reads zero", d, 32'd0);

        for (int w = 0; w < 6; w++) window_check();

        summary();
        $finish;
    end

endmodule